// File: doc/BRIEF.md
# Word Register Bank with Pipelined Bus Slave Port

This block is a small peripheral that holds a bank of general-purpose data registers (eight words of 32 bits by default). A bus master reaches the bank through a pipelined slave port: in one cycle the master presents address and control, and in the next cycle the data moves. A compact three-state controller (idle, read, write) records each accepted address phase. It then carries out the register access in the following cycle, so write data is taken one cycle after its address.

Writes may be a full word, a halfword or a single byte. A narrow write changes only the byte lanes that it addresses. Every access completes without wait states and always reports a good response. Burst beats are handled as a string of unrelated single transfers. Idle and busy transfer slots, deselected cycles and cycles where the shared bus is stalled do not touch the bank.

Top module: `wordreg_bank`

## Requirements
- R1: While `rst_n` is low, every register is cleared to zero and `rdata_o` is zero. After reset, every register reads back as zero.
- R2: A full-word write (`size_i` = 2) followed by a read of the same word address returns the written value. The register index is `addr_i[4:2]`, and the eight registers are independent of one another.
- R3: The bank stores the value on `wdata_i` during the data phase, which is the cycle after the accepted address phase. The value on `wdata_i` during the address phase is ignored.
- R4: Transfer types are coded on `trans_i` as 00 idle, 01 busy, 10 non-sequential and 11 sequential. Only codes with bit 1 set start an access. Idle and busy slots leave every register unchanged.
- R5: An address phase is accepted only when `sel_i` and `rdy_i` are both high. With either one low, no register changes.
- R6: A byte write (`size_i` = 0) updates only lane `addr_i[1:0]`, which is bits 8*lane+7 down to 8*lane. A halfword write (`size_i` = 1) updates only lanes 2*`addr_i[1]` and 2*`addr_i[1]`+1. Other lanes keep their values.
- R7: `rdata_o` carries the addressed register during a read data phase and is zero in every other cycle. This includes write data phases and cycles after a rejected address phase.
- R8: `rdy_o` is always 1 and `resp_o` is always 00 (good response). Every access takes zero wait states.
- R9: A read whose address phase falls in the same cycle as the data phase of a write to the same register returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Slave select from the address decoder |
| rdy_i | input | 1 | Bus-wide ready; high when the previous transfer has finished |
| trans_i | input | 2 | Transfer type (00 idle, 01 busy, 10 non-sequential, 11 sequential) |
| size_i | input | 3 | Transfer size as log2 of the byte count |
| wr_i | input | 1 | Direction: 1 write, 0 read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data, valid in the data phase |
| rdy_o | output | 1 | Transfer-done indication from this slave (always high) |
| resp_o | output | 2 | Transfer response (always 00) |
| rdata_o | output | DATA_W | Read data, valid in the read data phase |

## Verification
The data phase of one transfer and the address phase of the next share a cycle. The interesting overlap is therefore a write data phase for a register running alongside a new address phase that reads the same register. The bench provokes this by issuing a write and then, with no gap, a read of the same word. It judges the result by requiring the read to return the new value, not the old one. A second overlap places a rejected address phase (idle, busy, deselected or stalled) beside a write data phase. The bench checks that the pending write still lands and that the rejected slot neither writes nor drives read data.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'b00,
      PH_READ  = 2'b01,
      PH_WRITE = 2'b10
   } phase_e;

   localparam logic [1:0] RESP_GOOD = 2'b00;
   localparam logic [1:0] RESP_FAIL = 2'b01;

endpackage

// File: rtl/regbank_addr_ctl.sv
module regbank_addr_ctl
   import regbank_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 3,
   parameter int OFS_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              rdy,
   input  logic [1:0]        trans,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size,
   output phase_e            phase,
   output logic [IDX_W-1:0]  idx,
   output logic [OFS_W-1:0]  off,
   output logic [2:0]        sz
);

   logic accept;

   // Bit 1 of the transfer type separates the active types from idle and busy.
   assign accept = sel && rdy && trans[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         idx   <= '0;
         off   <= '0;
         sz    <= '0;
      end else if (accept) begin
         phase <= wr ? PH_WRITE : PH_READ;
         idx   <= addr[OFS_W +: IDX_W];
         off   <= addr[OFS_W-1:0];
         sz    <= size;
      end else begin
         phase <= PH_IDLE;
      end
   end

endmodule

// File: rtl/regbank_lane_strobe.sv
module regbank_lane_strobe #(
   parameter int LANES = 4,
   parameter int OFS_W = 2
) (
   input  logic [OFS_W-1:0] off,
   input  logic [2:0]       sz,
   output logic [LANES-1:0] strb
);

   // A lane is written when its index and the byte offset agree above the size bits.
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam logic [OFS_W-1:0] LANE_ID = OFS_W'(l);
      assign strb[l] = ((LANE_ID ^ off) >> sz) == '0;
   end

endmodule

// File: rtl/regbank_array.sv
module regbank_array #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 32,
   parameter int IDX_W    = 3,
   parameter int LANES    = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           idx,
   input  logic [LANES-1:0]           strb,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rd_word,
   output logic [NUM_REGS*DATA_W-1:0] flat
);

   logic [DATA_W-1:0] mem [NUM_REGS];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(r);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem[r] <= '0;
         end else if (wr_en && idx == MY_IDX) begin
            for (int b = 0; b < LANES; b++) begin
               if (strb[b]) mem[r][8*b +: 8] <= wdata[8*b +: 8];
            end
         end
      end
      assign flat[r*DATA_W +: DATA_W] = mem[r];
   end

   assign rd_word = mem[idx];

endmodule

// File: rtl/wordreg_bank.sv
module wordreg_bank
   import regbank_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              rdy_i,
   input  logic [1:0]        trans_i,
   input  logic [2:0]        size_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              rdy_o,
   output logic [1:0]        resp_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int LANES = DATA_W / 8;
   localparam int OFS_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   initial begin
      if (DATA_W % 8 != 0 || DATA_W < 16)
         $error("DATA_W must be a multiple of 8 and at least 16");
      if ((1 << IDX_W) != NUM_REGS)
         $error("NUM_REGS must be a power of two");
      if (ADDR_W < OFS_W + IDX_W)
         $error("ADDR_W too small for the register window");
   end

   phase_e                     phase;
   logic [IDX_W-1:0]           idx;
   logic [OFS_W-1:0]           off;
   logic [2:0]                 sz;
   logic [LANES-1:0]           strb;
   logic [DATA_W-1:0]          rd_word;
   logic [NUM_REGS*DATA_W-1:0] reg_flat;

   regbank_addr_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .sel(sel_i), .rdy(rdy_i), .trans(trans_i),
      .wr(wr_i), .addr(addr_i), .size(size_i),
      .phase(phase), .idx(idx), .off(off), .sz(sz)
   );

   regbank_lane_strobe #(.LANES(LANES), .OFS_W(OFS_W)) u_strb (
      .off(off), .sz(sz), .strb(strb)
   );

   regbank_array #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W), .LANES(LANES)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(phase == PH_WRITE), .idx(idx),
      .strb(strb), .wdata(wdata_i), .rd_word(rd_word), .flat(reg_flat)
   );

   assign rdy_o   = 1'b1;
   assign resp_o  = RESP_GOOD;
   assign rdata_o = (phase == PH_READ) ? rd_word : '0;

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
   parameter int DATA_W = 32,
   parameter int FLAT_W = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_i,
   input logic              rdy_i,
   input logic [1:0]        trans_i,
   input logic              wr_i,
   input logic              rdy_o,
   input logic [1:0]        resp_o,
   input logic [DATA_W-1:0] rdata_o,
   input logic [FLAT_W-1:0] reg_flat
);

   // R1: bank and read data held at zero during reset
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |-> (reg_flat == '0 && rdata_o == '0));

   // R8: zero wait states, good response
   p_ready_good_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_o == 1'b1 && resp_o == 2'b00);

   // R7: no read address phase accepted means no read data next cycle
   p_rdata_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_i && rdy_i && trans_i[1] && !wr_i) |=> rdata_o == '0);

   // R4 / R5: without an accepted write address phase the bank does not change
   p_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_i && rdy_i && trans_i[1] && wr_i) |=> ##1 $stable(reg_flat));

endmodule

bind wordreg_bank regbank_chk #(.DATA_W(DATA_W), .FLAT_W(NUM_REGS*DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .rdy_i(rdy_i), .trans_i(trans_i),
   .wr_i(wr_i), .rdy_o(rdy_o), .resp_o(resp_o), .rdata_o(rdata_o), .reg_flat(reg_flat)
);

// File: tb/test_wordreg_bank.sv
`timescale 1ns/1ps
module test_wordreg_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_i = 1'b0, rdy_i = 1'b1, wr_i = 1'b0;
   logic [1:0]  trans_i = 2'b00;
   logic [2:0]  size_i = 3'd2;
   logic [31:0] addr_i = '0, wdata_i = '0;
   logic        rdy_o;
   logic [1:0]  resp_o;
   logic [31:0] rdata_o;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [31:0] model [8];

   always #2 clk = ~clk;

   wordreg_bank i_wordreg_bank (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .rdy_i(rdy_i), .trans_i(trans_i),
      .size_i(size_i), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
      .rdy_o(rdy_o), .resp_o(resp_o), .rdata_o(rdata_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One transfer: address phase, then data phase with read data sampled.
   task automatic xfer(input logic s, input logic r, input logic [1:0] t, input logic w,
                       input int idx, input int off, input logic [2:0] sz,
                       input logic [31:0] d, output logic [31:0] rd);
      @(negedge clk);
      sel_i = s; rdy_i = r; trans_i = t; wr_i = w; size_i = sz;
      addr_i = 32'(idx * 4 + off); wdata_i = ~d;   // R3: address-phase data must be ignored
      @(negedge clk);
      rd = rdata_o;
      check("R8 ready", {31'd0, rdy_o}, 32'd1);
      check("R8 resp", {30'd0, resp_o}, 32'd0);
      sel_i = 1'b0; trans_i = 2'b00; wdata_i = d;
   endtask

   task automatic wr_word(input int idx, input int off, input logic [2:0] sz, input logic [31:0] d);
      logic [31:0] rd;
      logic [31:0] m;
      xfer(1, 1, 2'b10, 1, idx, off, sz, d, rd);
      check("R7 rdata zero in write phase", rd, 32'd0);
      // Expected lane update: lanes sharing the offset bits above size
      m = model[idx];
      for (int l = 0; l < 4; l++)
         if (((l ^ off) >> sz) == 0) m[8*l +: 8] = d[8*l +: 8];
      model[idx] = m;
   endtask

   task automatic rd_check(input string req, input int idx);
      logic [31:0] rd;
      xfer(1, 1, 2'b11, 0, idx, 0, 3'd2, 32'h0, rd);
      check(req, rd, model[idx]);
   endtask

   initial begin
      logic [31:0] rd;
      for (int i = 0; i < 8; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      check("R1 rdata in reset", rdata_o, 32'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) rd_check("R1 reset value", i);

      // R2 / R3: full-word sweep over all registers
      for (int i = 0; i < 8; i++) wr_word(i, 0, 3'd2, 32'h1357_9BDF * (i + 1) + 32'h0101_0101);
      for (int i = 0; i < 8; i++) rd_check("R2 word readback", i);

      // R6: every byte lane of every register, then every halfword
      for (int i = 0; i < 8; i++)
         for (int l = 0; l < 4; l++) begin
            wr_word(i, l, 3'd0, {4{8'(8'hA0 + i * 4 + l)}});
            rd_check("R6 byte lane", i);
         end
      for (int i = 0; i < 8; i++)
         for (int h = 0; h < 2; h++) begin
            wr_word(i, 2 * h, 3'd1, {2{16'(16'hC000 + i * 2 + h)}});
            rd_check("R6 halfword lanes", i);
         end

      // R4: idle and busy slots with write direction leave the bank alone
      for (int t = 0; t < 2; t++)
         for (int i = 0; i < 8; i++) begin
            xfer(1, 1, 2'(t), 1, i, 0, 3'd2, 32'hDEAD_0000 + i, rd);
            check("R7 rdata zero after rejected slot", rd, 32'd0);
            rd_check("R4 idle/busy no write", i);
         end

      // R5: deselected or stalled cycles are not accepted
      for (int i = 0; i < 8; i++) begin
         xfer(0, 1, 2'b10, 1, i, 0, 3'd2, 32'hBAD0_0000 + i, rd);
         rd_check("R5 deselected no write", i);
         xfer(1, 0, 2'b10, 1, i, 0, 3'd2, 32'hBAD1_0000 + i, rd);
         rd_check("R5 stalled no write", i);
         xfer(1, 0, 2'b10, 0, i, 0, 3'd2, 32'h0, rd);
         check("R7 stalled read gives zero", rd, 32'd0);
      end

      // R9: write data phase overlaps the read address phase of the same register
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         sel_i = 1; rdy_i = 1; trans_i = 2'b10; wr_i = 1; size_i = 3'd2;
         addr_i = 32'(i * 4); wdata_i = 32'h0;
         @(negedge clk);
         wdata_i = 32'h5A5A_0000 + 32'(i);
         trans_i = 2'b11; wr_i = 0;
         model[i] = 32'h5A5A_0000 + 32'(i);
         @(negedge clk);
         check("R9 back-to-back read sees new data", rdata_o, model[i]);
         sel_i = 0; trans_i = 2'b00;
      end
      for (int i = 0; i < 8; i++) rd_check("R2 final readback", i);

      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule